// File: doc/BRIEF.md
# PCI Posted Write Combining Buffer

This block sits between a processor-side posted write port and the request port of a PCI bus master. Each incoming request is one doubleword beat: a 4-bit PCI command, a byte address, 32 data bits and four byte enables. When successive Memory Write (`4'b0111`) or Memory Write and Invalidate (`4'b1111`) requests carry the same command and each lands on the doubleword directly above the previous one, the buffer collects them into one burst. It then hands that burst to the bus side as a single transaction. The transaction has a start address, a command, a beat count and a stream of beats, all under valid/ready handshaking. Any other command is passed on as a transaction of its own.

A burst is closed for any of these reasons:
- an address that is not strictly the next doubleword (lower, repeated or skipped);
- a change of command;
- a non-combinable request waiting at the input;
- a one-cycle ordering barrier strobe;
- a full buffer;
- a run of idle cycles with no write offered.

Requests are accepted one at a time and come out in their original order.

The controller has three states:
- **ST_EMPTY**: no burst is open and every request is accepted. A combinable request moves the controller to **ST_GATHER**. Any other request moves it to **ST_ISSUE** as a one-beat transaction.
- **ST_GATHER**: a burst is open. A joining request is appended, and the append that fills the last slot moves the controller to **ST_ISSUE**. Any of the following closes the burst by moving to **ST_ISSUE** without accepting: a non-joining request, a barrier, or an expired idle timer.
- **ST_ISSUE**: the burst is driven onto the output. The handshake of the final beat returns the controller to **ST_EMPTY**.

Top module: `pci_write_combiner`

## Requirements
- R1: After reset, out_valid is 0, and in_ready is 1 while in_valid is offered.
- R2: Memory Write requests at ascending, adjacent doubleword addresses (each address is the previous one plus 4) leave as one transaction. Its out_addr is the first address, its out_count is the number of requests, and it carries their data and byte enables in arrival order.
- R3: A request whose command is neither 4'b0111 nor 4'b1111 leaves as its own transaction with out_count 1. While a burst is open, such a request is held off (in_ready 0) until the open burst has been issued.
- R4: A change between 4'b0111 and 4'b1111 closes the open burst. The new request starts a new transaction.
- R5: A request whose address is lower than, equal to, or more than one doubleword above the next expected address closes the open burst. That request starts a new transaction.
- R6: An in_barrier strobe while a burst is open closes it. A request offered in the same cycle as the strobe is not accepted until the burst has been issued.
- R7: A burst holds at most DEPTH beats. The request that fills it closes it, and the next joining request opens a new transaction.
- R8: If no request is offered for IDLE_LIMIT consecutive cycles after the last accepted one, the open burst is issued. out_valid rises IDLE_LIMIT+1 cycles after the accepting clock edge.
- R9: While out_valid is 1 and out_ready is 0, all output fields hold steady. in_ready is 0 while a transaction is being issued.
- R10: A transaction delivers exactly out_count beats. out_last is 1 on the final beat only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write request offered |
| in_ready | output | 1 | Request taken this cycle |
| in_cmd | input | 4 | PCI command of the request |
| in_addr | input | AW | Doubleword-aligned byte address |
| in_data | input | DW | Write data |
| in_be | input | DW/8 | Byte enables |
| in_barrier | input | 1 | One-cycle ordering barrier strobe |
| out_valid | output | 1 | Transaction beat valid |
| out_ready | input | 1 | Bus side takes the beat |
| out_addr | output | AW | Transaction start address |
| out_cmd | output | 4 | Transaction command |
| out_count | output | $clog2(DEPTH+1) | Beats in the transaction |
| out_data | output | DW | Beat data |
| out_be | output | DW/8 | Beat byte enables |
| out_last | output | 1 | Final beat of the transaction |

## Verification
The properties assume that a request, once offered, stays on the input with the same fields until it is accepted. They also assume that addresses are doubleword aligned and that in_barrier is a single-cycle strobe. The bench's write task sets the fields once, holds them until a clock edge where in_ready was seen high, and drops the barrier after its first cycle. out_ready follows a fixed stall pattern, which exercises held beats throughout without any assumption on the bus side.

// File: rtl/pci_wc_pkg.sv
package pci_wc_pkg;
    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_GATHER,
        ST_ISSUE
    } wc_state_t;

    function automatic logic cmd_mergeable(input logic [3:0] c);
        return (c == CMD_MEM_WR) || (c == CMD_MEM_WR_INV);
    endfunction
endpackage

// File: rtl/pci_wc_store.sv
module pci_wc_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int IDXW  = 3
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW/8-1:0]    wr_be,
    input  logic [IDXW-1:0]    rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic [DW/8-1:0]    rd_be
);
    logic [DW-1:0]   data_q [DEPTH];
    logic [DW/8-1:0] be_q   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDXW'(g))) begin
                data_q[g] <= wr_data;
                be_q[g]   <= wr_be;
            end
        end
    end

    assign rd_data = data_q[rd_idx];
    assign rd_be   = be_q[rd_idx];
endmodule

// File: rtl/pci_wc_timer.sv
module pci_wc_timer #(
    parameter int LIMIT = 16,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pci_wc_join.sv
module pci_wc_join
    import pci_wc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [3:0]    in_cmd,
    input  logic [3:0]    cur_cmd,
    input  logic [AW-1:0] in_addr,
    input  logic [AW-1:0] next_addr,
    output logic          join_ok
);
    assign join_ok = cmd_mergeable(in_cmd) && (in_cmd == cur_cmd)
                   && (in_addr == next_addr);
endmodule

// File: rtl/pci_write_combiner.sv
module pci_write_combiner
    import pci_wc_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int IDLE_LIMIT = 16,
    localparam int BEW       = DW / 8,
    localparam int CNTW      = $clog2(DEPTH + 1),
    localparam int IDXW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [3:0]      in_cmd,
    input  logic [AW-1:0]   in_addr,
    input  logic [DW-1:0]   in_data,
    input  logic [BEW-1:0]  in_be,
    input  logic            in_barrier,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [AW-1:0]   out_addr,
    output logic [3:0]      out_cmd,
    output logic [CNTW-1:0] out_count,
    output logic [DW-1:0]   out_data,
    output logic [BEW-1:0]  out_be,
    output logic            out_last
);
    wc_state_t       state, state_nxt;
    logic [CNTW-1:0] fill, rd;
    logic [AW-1:0]   base;
    logic [3:0]      cmd;
    logic [AW-1:0]   next_addr;
    logic            join_ok, expired, accept, last_beat;

    assign next_addr = base + AW'(32'(fill) * BEW);
    assign accept    = in_valid && in_ready;
    assign last_beat = (rd == fill - CNTW'(1));

    pci_wc_join #(.AW(AW)) u_join (
        .in_cmd   (in_cmd),
        .cur_cmd  (cmd),
        .in_addr  (in_addr),
        .next_addr(next_addr),
        .join_ok  (join_ok)
    );

    pci_wc_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  ((state != ST_GATHER) || accept),
        .tick   ((state == ST_GATHER) && !in_valid),
        .expired(expired)
    );

    pci_wc_store #(.DEPTH(DEPTH), .DW(DW), .IDXW(IDXW)) u_store (
        .clk    (clk),
        .wr_en  (accept),
        .wr_idx ((state == ST_EMPTY) ? '0 : fill[IDXW-1:0]),
        .wr_data(in_data),
        .wr_be  (in_be),
        .rd_idx (rd[IDXW-1:0]),
        .rd_data(out_data),
        .rd_be  (out_be)
    );

    // Transition and handshake decode
    always_comb begin
        state_nxt = state;
        in_ready  = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    state_nxt = (cmd_mergeable(in_cmd) && DEPTH > 1)
                              ? ST_GATHER : ST_ISSUE;
                end
            end
            ST_GATHER: begin
                in_ready = join_ok && !in_barrier && !expired;
                if (in_valid && in_ready) begin
                    if (fill == CNTW'(DEPTH - 1)) state_nxt = ST_ISSUE;
                end else if (in_valid || in_barrier || expired) begin
                    state_nxt = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (out_ready && last_beat) state_nxt = ST_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
            rd   <= '0;
            base <= '0;
            cmd  <= '0;
        end else begin
            if (accept && state == ST_EMPTY) begin
                base <= in_addr;
                cmd  <= in_cmd;
                fill <= CNTW'(1);
            end else if (accept) begin
                fill <= fill + CNTW'(1);
            end
            if (state == ST_ISSUE && out_ready) begin
                rd <= last_beat ? '0 : rd + CNTW'(1);
            end
        end
    end

    assign out_valid = (state == ST_ISSUE);
    assign out_addr  = base;
    assign out_cmd   = cmd;
    assign out_count = fill;
    assign out_last  = (state == ST_ISSUE) && last_beat;
endmodule

// File: rtl/pci_write_combiner_chk.sv
module pci_write_combiner_chk
    import pci_wc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [3:0]      in_cmd,
    input logic            in_barrier,
    input logic            out_valid,
    input logic            out_ready,
    input logic [AW-1:0]   out_addr,
    input logic [3:0]      out_cmd,
    input logic [CNTW-1:0] out_count,
    input logic [DW-1:0]   out_data,
    input logic [DW/8-1:0] out_be,
    input logic            out_last
);
    logic open;

    always_ff @(posedge clk) begin
        if (!rst_n)                                open <= 1'b0;
        else if (in_valid && in_ready)             open <= 1'b1;
        else if (out_valid && out_ready && out_last) open <= 1'b0;
    end

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid
            && $stable({out_addr, out_cmd, out_count, out_data, out_be, out_last}));

    p_no_take_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= CNTW'(1)) && (out_count <= CNTW'(DEPTH)));

    p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

    p_single_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !cmd_mergeable(out_cmd) |-> out_count == CNTW'(1));

    p_plain_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && open && !cmd_mergeable(in_cmd) |-> !in_ready);

    p_barrier_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_barrier && open |-> !in_ready);
endmodule

bind pci_write_combiner pci_write_combiner_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/pci_write_combiner_test.sv
`timescale 1ns/100ps
module pci_write_combiner_test;
    localparam int DEPTH = 8;
    localparam int LIMIT = 6;

    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, in_barrier = 0, out_ready = 1;
    logic [3:0]  in_cmd = 0;
    logic [31:0] in_addr = 0, in_data = 0;
    logic [3:0]  in_be = 0;
    logic        in_ready, out_valid, out_last;
    logic [31:0] out_addr, out_data;
    logic [3:0]  out_cmd, out_be;
    logic [3:0]  out_count;

    int tests = 0, fails = 0;
    int bq[$];

    // reference model state
    int          m_st = 0, m_idle = 0, m_rd = 0;
    logic [31:0] m_d[$];
    logic [3:0]  m_b[$];
    logic [31:0] m_base = 0;
    logic [3:0]  m_cmd = 0;

    pci_write_combiner #(.DEPTH(DEPTH), .IDLE_LIMIT(LIMIT)) uut (.*);

    always #2.5 clk = ~clk;

    function automatic bit mergeable(logic [3:0] c);
        return c == 4'b0111 || c == 4'b1111;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int  sz;
        bit  joinok, erdy;
        if (!rst_n) begin
            m_st = 0; m_idle = 0; m_rd = 0; m_d.delete(); m_b.delete();
        end else begin
            sz     = m_d.size();
            joinok = mergeable(in_cmd) && in_cmd == m_cmd
                   && in_addr == m_base + 32'(4 * sz);
            erdy   = (m_st == 0) || (m_st == 1 && joinok && !in_barrier && m_idle < LIMIT);
            if (in_valid)
                chk(in_ready == erdy, "R3/R5/R6 in_ready", 32'(in_ready), 32'(erdy));
            chk(out_valid == (m_st == 2), "R8/R9 out_valid", 32'(out_valid), 32'(m_st == 2));
            if (m_st == 2 && out_valid) begin
                chk(out_addr == m_base, "R2 out_addr", out_addr, m_base);
                chk(out_cmd == m_cmd, "R4 out_cmd", 32'(out_cmd), 32'(m_cmd));
                chk(32'(out_count) == 32'(sz), "R7 out_count", 32'(out_count), 32'(sz));
                chk(out_data == m_d[m_rd], "R2/R9 out_data", out_data, m_d[m_rd]);
                chk(out_be == m_b[m_rd], "R2 out_be", 32'(out_be), 32'(m_b[m_rd]));
                chk(out_last == (m_rd == sz - 1), "R10 out_last", 32'(out_last),
                    32'(m_rd == sz - 1));
                if (out_ready && out_last) bq.push_back(int'(out_count));
            end
            case (m_st)
                0: if (in_valid) begin
                    m_d.push_back(in_data); m_b.push_back(in_be);
                    m_base = in_addr; m_cmd = in_cmd; m_idle = 0; m_rd = 0;
                    m_st = (mergeable(in_cmd) && DEPTH > 1) ? 1 : 2;
                end
                1: if (in_valid && erdy) begin
                    m_d.push_back(in_data); m_b.push_back(in_be); m_idle = 0;
                    if (m_d.size() == DEPTH) m_st = 2;
                end else if (in_valid || in_barrier || m_idle >= LIMIT) begin
                    m_st = 2;
                end else begin
                    m_idle++;
                end
                default: if (out_ready) begin
                    if (m_rd == sz - 1) begin
                        m_st = 0; m_rd = 0; m_d.delete(); m_b.delete();
                    end else m_rd++;
                end
            endcase
        end
    end

    task automatic wr(logic [3:0] c, logic [31:0] a, bit bar = 0);
        bit acc;
        in_valid = 1; in_cmd = c; in_addr = a;
        in_data = a ^ 32'h5A3C_0000; in_be = a[5:2] | 4'b0001; in_barrier = bar;
        forever begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #1; in_barrier = 0;
            if (acc) break;
        end
        in_valid = 0;
    endtask

    task automatic pulse_barrier();
        in_barrier = 1; @(posedge clk); #1; in_barrier = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && (m_st != 0 || out_valid); i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic expect_bursts(string tag, int n, int c0, int c1 = 0, int c2 = 0);
        int e[3];
        e = '{c0, c1, c2};
        drain();
        chk(bq.size() == n, {tag, " burst total"}, 32'(bq.size()), 32'(n));
        for (int i = 0; i < n && i < bq.size(); i++)
            chk(bq[i] == e[i], {tag, " burst size"}, 32'(bq[i]), 32'(e[i]));
        bq.delete();
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = ($time % 7) > 2;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        in_valid = 1;
        @(negedge clk);
        chk(out_valid == 0, "R1 reset out_valid", 32'(out_valid), 0);
        chk(in_ready == 1, "R1 reset in_ready", 32'(in_ready), 1);
        in_valid = 0;
        @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #1;

        // R2: four adjacent writes, closed by a barrier pulse
        for (int i = 0; i < 4; i++) wr(4'b0111, 32'h100 + 32'(4 * i));
        pulse_barrier();
        expect_bursts("R2", 1, 4);

        // R7: ten adjacent writes split at DEPTH
        for (int i = 0; i < 10; i++) wr(4'b1111, 32'h1000 + 32'(4 * i));
        expect_bursts("R7", 2, 8, 2);

        // R5: overlap, lower and gapped addresses
        wr(4'b0111, 32'h200); wr(4'b0111, 32'h204);
        wr(4'b0111, 32'h200); wr(4'b0111, 32'h204);
        wr(4'b0111, 32'h20C);
        expect_bursts("R5", 3, 2, 2, 1);

        // R4: command change closes burst
        wr(4'b0111, 32'h300); wr(4'b1111, 32'h304);
        expect_bursts("R4", 2, 1, 1);

        // R3: non-combinable write between combinable ones
        wr(4'b0111, 32'h400); wr(4'b0011, 32'h404); wr(4'b0111, 32'h408);
        expect_bursts("R3", 3, 1, 1, 1);

        // R6: barrier in the same cycle as a write, then a lone pulse
        wr(4'b0111, 32'h500); wr(4'b0111, 32'h504); wr(4'b0111, 32'h508, 1);
        expect_bursts("R6", 2, 2, 1);
        wr(4'b0111, 32'h600); wr(4'b0111, 32'h604); pulse_barrier();
        wr(4'b0111, 32'h608);
        expect_bursts("R6", 2, 2, 1);

        // R8: idle timeout latency
        wr(4'b0111, 32'h700);
        n = 0;
        forever begin
            @(negedge clk);
            if (out_valid || n > 100) break;
            n++;
        end
        chk(n == LIMIT + 1, "R8 idle latency", 32'(n), 32'(LIMIT + 1));
        @(posedge clk); #1;
        expect_bursts("R8", 1, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule